// File: doc/BRIEF.md
# Staggered Dual-Group Conversion Sequencer

This block drives the two conversion-start lines of an eight-channel simultaneous-sampling converter. The inputs of that converter are split into two groups of four. A rising edge on a group's start line freezes all four of its inputs at once. The converter does not begin converting until both groups have been frozen.

On a start request, the block raises the group A line. It then counts a programmable skew and raises the group B line. The skew lets a system line up signals whose front-end paths differ in delay, for example the voltage and current channels of a protection relay. After both edges, the block follows the converter's busy output through a synchronizer. It checks that busy rises within a timeout and falls within a maximum conversion time. When busy falls, it emits a one-cycle done strobe that tells the readout logic data are ready.

The sequencer does not depend on how the data are read back afterwards. It refuses to run while the converter's oversampling is enabled.

Top module: `dual_group_sampler`

## Requirements
- R1: After reset, both start lines, `seq_active`, `done_pulse` and all three bits of `err_flags` are 0.
- R2: An accepted request raises `conv_a` in the cycle after the clock edge that samples `start_req`. `conv_b` rises exactly S cycles after `conv_a`, where S is `skew_cfg` captured at acceptance. With S = 0, both lines rise in the same cycle.
- R3: Each start line stays high for exactly P cycles, where P is `pulse_cfg` captured at acceptance. A value of 0 is treated as 1.
- R4: If `ovs_en` is 1 when an idle request arrives, no start line rises, no sequence begins, and `err_flags` bit 0 is set.
- R5: Busy activity between the group A edge and the group B edge is ignored. It produces no done strobe and no error.
- R6: If the synchronized busy does not rise, `err_flags` bit 1 is set and `seq_active` falls. This happens exactly S + T + 1 cycles after `conv_a` rises, where T is `rise_tmo_cfg`.
- R7: A busy pulse of L cycles with L > M, where M is `conv_max_cfg`, sets `err_flags` bit 2, ends the sequence and gives no done strobe. A pulse with L ≤ M is accepted without error.
- R8: A normal conversion ends with exactly one `done_pulse`, one cycle wide. It appears in the third cycle after the cycle in which `adc_busy` goes low, and `seq_active` is 0 with it.
- R9: A request made while a sequence is active is ignored, as is a request made while either start line is still high. At most one `conv_a` rising edge occurs per sequence.
- R10: Error bits are sticky until reset. A later error-free sequence still runs and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to begin a sequence |
| ovs_en | input | 1 | Converter oversampling is enabled; blocks starting |
| skew_cfg | input | SKEW_W | Clocks from group A edge to group B edge |
| pulse_cfg | input | PW_W | Start-line high time in clocks (0 acts as 1) |
| rise_tmo_cfg | input | TO_W | Timeout for busy to rise after the group B edge |
| conv_max_cfg | input | TO_W | Longest accepted busy high time in clocks |
| adc_busy | input | 1 | Converter busy output, asynchronous |
| conv_a | output | 1 | Start line for group A (channels 1 to 4) |
| conv_b | output | 1 | Start line for group B (channels 5 to 8) |
| seq_active | output | 1 | A sequence is in progress |
| done_pulse | output | 1 | One-cycle strobe: conversion finished, data readable |
| err_flags | output | 3 | Sticky: bit0 oversampling refused, bit1 busy never rose, bit2 busy too long |

## Verification
A stuck or miscounted skew register shows at once as a wrong distance between the two start-line edges. That distance is visible within S cycles of the request. A state machine that leaves the wait or conversion state too early or too late moves the error bit or the done strobe off its exact cycle, so every sequence pins its timing to a single clock. A corrupted pulse-width counter shows as a start line held one cycle too long or too short. A lost sticky bit shows on the next sequence that follows an error.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SKEW = 2'd1,
        ST_WAIT = 2'd2,
        ST_CONV = 2'd3
    } seq_state_e;

    localparam int NUM_GRP    = 2;
    localparam int ERR_W      = 3;
    localparam int ERR_OVS    = 0;
    localparam int ERR_NORISE = 1;
    localparam int ERR_LONG   = 2;

endpackage

// File: rtl/dgs_sync.sv
module dgs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/dgs_pulse.sv
module dgs_pulse #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_i,
    input  logic [PW_W-1:0] width_i,
    output logic            line_o
);
    typedef struct packed {
        logic            line;
        logic [PW_W-1:0] cnt;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (fire_i) begin
            p_d.line = 1'b1;
            p_d.cnt  = (width_i == '0) ? PW_W'(1) : width_i;
        end else if (p_q.line) begin
            if (p_q.cnt <= PW_W'(1)) p_d.line = 1'b0;
            else                     p_d.cnt  = p_q.cnt - PW_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign line_o = p_q.line;
endmodule

// File: rtl/dual_group_sampler.sv
module dual_group_sampler
    import dgs_pkg::*;
#(
    parameter int SKEW_W      = 16,
    parameter int PW_W        = 8,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              ovs_en,
    input  logic [SKEW_W-1:0] skew_cfg,
    input  logic [PW_W-1:0]   pulse_cfg,
    input  logic [TO_W-1:0]   rise_tmo_cfg,
    input  logic [TO_W-1:0]   conv_max_cfg,
    input  logic              adc_busy,
    output logic              conv_a,
    output logic              conv_b,
    output logic              seq_active,
    output logic              done_pulse,
    output logic [ERR_W-1:0]  err_flags
);
    localparam int GA = 0;
    localparam int GB = 1;

    typedef struct packed {
        seq_state_e        state;
        logic [SKEW_W-1:0] skew_cnt;
        logic [TO_W-1:0]   wcnt;
        logic [PW_W-1:0]   pw;
        logic [ERR_W-1:0]  err;
        logic              done;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:    ST_IDLE,
        skew_cnt: '0,
        wcnt:     '0,
        pw:       '0,
        err:      '0,
        done:     1'b0
    };

    regs_t r_d, r_q;

    logic [NUM_GRP-1:0] fire;
    logic [NUM_GRP-1:0] line;
    logic [PW_W-1:0]    width_sel [NUM_GRP];
    logic               busy_rise, busy_fall;
    logic               lines_low;

    dgs_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (adc_busy),
        .rise_o  (busy_rise),
        .fall_o  (busy_fall)
    );

    // Group A always fires from idle; group B may fire later from the latched width.
    assign width_sel[GA] = pulse_cfg;
    assign width_sel[GB] = (r_q.state == ST_IDLE) ? pulse_cfg : r_q.pw;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_line
        dgs_pulse #(.PW_W(PW_W)) u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (fire[g]),
            .width_i (width_sel[g]),
            .line_o  (line[g])
        );
    end

    assign lines_low = (line == '0);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fire     = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_req && lines_low) begin
                    if (ovs_en) begin
                        r_d.err[ERR_OVS] = 1'b1;
                    end else begin
                        fire[GA] = 1'b1;
                        r_d.pw   = pulse_cfg;
                        if (skew_cfg == '0) begin
                            fire[GB]  = 1'b1;
                            r_d.state = ST_WAIT;
                            r_d.wcnt  = '0;
                        end else begin
                            r_d.state    = ST_SKEW;
                            r_d.skew_cnt = skew_cfg;
                        end
                    end
                end
            end
            ST_SKEW: begin
                if (r_q.skew_cnt <= SKEW_W'(1)) begin
                    fire[GB]  = 1'b1;
                    r_d.state = ST_WAIT;
                    r_d.wcnt  = '0;
                end else begin
                    r_d.skew_cnt = r_q.skew_cnt - SKEW_W'(1);
                end
            end
            ST_WAIT: begin
                if (busy_rise) begin
                    r_d.state = ST_CONV;
                    r_d.wcnt  = '0;
                end else if (r_q.wcnt >= rise_tmo_cfg) begin
                    r_d.err[ERR_NORISE] = 1'b1;
                    r_d.state           = ST_IDLE;
                end else begin
                    r_d.wcnt = r_q.wcnt + TO_W'(1);
                end
            end
            ST_CONV: begin
                if (busy_fall) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (({1'b0, r_q.wcnt} + (TO_W+1)'(1)) >= {1'b0, conv_max_cfg}) begin
                    r_d.err[ERR_LONG] = 1'b1;
                    r_d.state         = ST_IDLE;
                end else begin
                    r_d.wcnt = r_q.wcnt + TO_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign conv_a     = line[GA];
    assign conv_b     = line[GB];
    assign seq_active = (r_q.state != ST_IDLE);
    assign done_pulse = r_q.done;
    assign err_flags  = r_q.err;
endmodule

// File: rtl/dgs_checker.sv
module dgs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ovs_en,
    input logic       conv_a,
    input logic       conv_b,
    input logic       seq_active,
    input logic       done_pulse,
    input logic [2:0] err_flags
);
    // R9
    a_edge_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_a) |-> !$past(seq_active));

    // R4
    ovs_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_a) |-> !$past(ovs_en));

    // R2
    b_edge_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_b) |-> seq_active);

    // R8
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R8
    done_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !seq_active);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != 3'b000) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R6
    new_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags & ~$past(err_flags)) != 3'b000) |-> !seq_active);
endmodule

bind dual_group_sampler dgs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovs_en     (ovs_en),
    .conv_a     (conv_a),
    .conv_b     (conv_b),
    .seq_active (seq_active),
    .done_pulse (done_pulse),
    .err_flags  (err_flags)
);

// File: tb/dual_group_sampler_tb.sv
module dual_group_sampler_tb;
    localparam int SKEW_W = 16;
    localparam int PW_W   = 8;
    localparam int TO_W   = 16;
    localparam int MAXC   = 12;
    localparam int TMO    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_req = 1'b0;
    logic              ovs_en = 1'b0;
    logic [SKEW_W-1:0] skew_cfg = '0;
    logic [PW_W-1:0]   pulse_cfg = '0;
    logic [TO_W-1:0]   rise_tmo_cfg = TO_W'(TMO);
    logic [TO_W-1:0]   conv_max_cfg = TO_W'(MAXC);
    logic              adc_busy = 1'b0;
    logic              conv_a, conv_b, seq_active, done_pulse;
    logic [2:0]        err_flags;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dual_group_sampler u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .ovs_en       (ovs_en),
        .skew_cfg     (skew_cfg),
        .pulse_cfg    (pulse_cfg),
        .rise_tmo_cfg (rise_tmo_cfg),
        .conv_max_cfg (conv_max_cfg),
        .adc_busy     (adc_busy),
        .conv_a       (conv_a),
        .conv_b       (conv_b),
        .seq_active   (seq_active),
        .done_pulse   (done_pulse),
        .err_flags    (err_flags)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic do_reset();
        rst_n     = 1'b0;
        start_req = 1'b0;
        adc_busy  = 1'b0;
        ovs_en    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Full sequence with a bench model of the converter's busy output.
    task automatic run_seq(input int s, input int p, input int lat, input int blen,
                           input bit spur, input int exp_err, input int exp_done);
        int  ar = -1, br = -1, a_hi = 0, b_hi = 0, a_rises = 0;
        int  dn = 0, dn_at = -1, bon = -1, boff = -1;
        bit  pa = 1'b0, pb = 1'b0;
        int  pw_exp = (p == 0) ? 1 : p;
        skew_cfg  = SKEW_W'(s);
        pulse_cfg = PW_W'(p);
        @(negedge clk);
        start_req = 1'b1;
        for (int c = 1; c <= s + lat + blen + p + 30; c++) begin
            @(negedge clk);
            if (conv_a && !pa) begin a_rises++; if (ar < 0) ar = c; end
            if (conv_b && !pb && br < 0) br = c;
            if (conv_a) a_hi++;
            if (conv_b) b_hi++;
            pa = conv_a;
            pb = conv_b;
            if (done_pulse) begin dn++; dn_at = c; end
            start_req = (c == 3);   // R9: request during an active sequence
            if (spur && ar >= 0 && c == ar + 1) adc_busy = 1'b1;
            if (spur && ar >= 0 && c == ar + 2) adc_busy = 1'b0;
            if (br >= 0 && c == br + lat) begin
                adc_busy = 1'b1;
                bon = c;
            end else if (bon >= 0 && c == bon + blen) begin
                adc_busy = 1'b0;
                boff = c;
            end
        end
        start_req = 1'b0;
        check($sformatf("R2 A edge s=%0d p=%0d", s, p), ar, 1);
        check($sformatf("R2 skew s=%0d p=%0d", s, p), br - ar, s);
        check($sformatf("R3 A width s=%0d p=%0d", s, p), a_hi, pw_exp);
        check($sformatf("R3 B width s=%0d p=%0d", s, p), b_hi, pw_exp);
        check($sformatf("R9 single A edge s=%0d", s), a_rises, 1);
        check($sformatf("R8 done count s=%0d blen=%0d", s, blen), dn, exp_done);
        if (exp_done == 1)
            check($sformatf("R8 done timing s=%0d", s), dn_at, boff + 3);
        check($sformatf("R7 err s=%0d blen=%0d", s, blen), err_flags, exp_err);
        check("R9 idle at end", seq_active, 0);
    endtask

    task automatic run_tmo(input int s, input int t);
        int ar = -1, eat = -1;
        rise_tmo_cfg = TO_W'(t);
        skew_cfg     = SKEW_W'(s);
        pulse_cfg    = PW_W'(1);
        @(negedge clk);
        start_req = 1'b1;
        for (int c = 1; c <= s + t + 20; c++) begin
            @(negedge clk);
            start_req = 1'b0;
            if (conv_a && ar < 0) ar = c;
            if (err_flags[1] && eat < 0) eat = c;
        end
        check($sformatf("R6 timeout cycle s=%0d t=%0d", s, t), eat, ar + s + t + 1);
        check($sformatf("R6 err bits s=%0d t=%0d", s, t), err_flags, 3'b010);
        check("R6 idle after timeout", seq_active, 0);
        rise_tmo_cfg = TO_W'(TMO);
    endtask

    initial begin
        int skews [5] = '{0, 1, 2, 5, 9};
        int pws   [3] = '{0, 1, 3};
        int tmos  [3] = '{0, 3, 7};
        int sks   [2] = '{0, 4};
        int hi_seen;
        do_reset();
        // R1
        check("R1 conv_a", conv_a, 0);
        check("R1 conv_b", conv_b, 0);
        check("R1 active", seq_active, 0);
        check("R1 done", done_pulse, 0);
        check("R1 err", err_flags, 0);

        // R2 R3 R8: skew and width sweep, busy length at the limit (R7 boundary)
        foreach (skews[i]) begin
            foreach (pws[j]) begin
                run_seq(skews[i], pws[j], 2, MAXC, 1'b0, 0, 1);
            end
        end
        run_seq(3, 2, 5, 1, 1'b0, 0, 1);

        // R5: spurious busy between the two edges
        run_seq(10, 2, 2, 4, 1'b1, 0, 1);

        // R7: busy one cycle too long
        run_seq(3, 1, 2, MAXC + 1, 1'b0, 3'b100, 0);

        // R6: busy never rises
        foreach (tmos[i]) begin
            foreach (sks[j]) begin
                do_reset();
                run_tmo(sks[j], tmos[i]);
            end
        end
        // R10: error stays, next sequence still completes
        run_seq(2, 2, 2, 4, 1'b0, 3'b010, 1);

        // R4: oversampling enabled refuses to start
        do_reset();
        ovs_en = 1'b1;
        hi_seen = 0;
        @(negedge clk);
        start_req = 1'b1;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            start_req = 1'b0;
            if (conv_a || conv_b || seq_active) hi_seen++;
        end
        check("R4 no start while oversampling", hi_seen, 0);
        check("R4 err bit0", err_flags, 3'b001);
        ovs_en = 1'b0;
        run_seq(1, 1, 2, 3, 1'b0, 3'b001, 1);

        summary();
        $finish;
    end
endmodule